// File: doc/BRIEF.md
# Victim Writeback Acceptance Controller

This block sits in front of a shared cache and takes in lines evicted from a lower-level cache. An eviction arrives on the request port as a victim announcement: dirty or clean, a shared hint, a requester ID and a line index. The controller records it in a small tracking table. It acknowledges the requester at once, and then waits for the matching data message on the data port. The data message carries its own shared and dirty bits. When data arrives, the controller computes the final stable state from three things: the state the line held before, the victim's kind, and the data's shared bit. It then writes the line, raises a recency (MRU) strobe when the victim hit a line that was already valid, and emits an unblock strobe towards the directory.

A requester can withdraw its pending writeback with a cancel request. The cancel is taken only from the requester that the table recorded. Because the line store is not touched while a writeback is pending, a cancel leaves the line exactly in its prior state.

The request and data ports are valid/ready. A transfer happens on a rising clock edge where both are high. While ready is low, the sender must hold the message stable and keep valid high. The acknowledge, unblock and MRU outputs are single-cycle strobes with no ready; the receivers must always take them. A lookup port shows the stored state of any line, and whether a writeback is pending on it.

Top module: `vwb_accept_ctrl`

## Requirements
- R1: After reset every line reads state I (encoding I=0, S=1, E=2, O=3, M=4 on look_state) with dirty 0, no line is busy, and ack_valid, unb_valid and mru_valid are low.
- R2: An accepted victim request (req_cancel=0) produces ack_valid for exactly the next cycle, carrying the request's req_src and req_line, and look_busy is high for that line from then on.
- R3: A victim request is held off (req_ready low) while its line already has a pending writeback, or while all TRK tracking entries (default 4) are in use.
- R4: For a line that was I: a dirty victim ends in M if the data is not shared and O if it is; a dirty victim flagged shared ends in O regardless of the data; a clean victim ends in E or S by the data's shared bit; a clean victim flagged shared ends in S. A line that was E resolves by the same rules.
- R5: For a line that was S, a dirty victim ends in O and a clean one in S; a line that was O ends in O; a line that was M ends in O if the data is shared, otherwise M.
- R6: Completion stores dat_payload in the line; the line's dirty bit becomes 1 when dat_dirty is 1 and otherwise keeps its old value.
- R7: mru_valid pulses for one cycle with the line index after a completion whose prior state was not I, and stays low after a completion onto an I line.
- R8: unb_valid pulses for one cycle with the line index after every completion and every accepted cancel.
- R9: A cancel (req_cancel=1) is accepted only when its line has a pending writeback recorded for the same req_src; otherwise req_ready stays low, so the requester retries it, and nothing changes.
- R10: An accepted cancel frees the tracking entry and leaves the line's state, dirty bit and data as they were before the victim request.
- R11: A data message whose line has no pending writeback is held off (dat_ready low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_cancel | input | 1 | 1 = cancel, 0 = victim announcement |
| req_dirty | input | 1 | Victim is dirty |
| req_shared | input | 1 | Victim flagged shared |
| req_src | input | SRC_W | Requester ID |
| req_line | input | LINE_W | Line index |
| ack_valid | output | 1 | Writeback acknowledge strobe |
| ack_src | output | SRC_W | Acknowledged requester |
| ack_line | output | LINE_W | Acknowledged line |
| dat_valid | input | 1 | Data message valid |
| dat_ready | output | 1 | Data accepted this cycle |
| dat_line | input | LINE_W | Data line index |
| dat_shared | input | 1 | Data carries shared bit |
| dat_dirty | input | 1 | Data marked dirty |
| dat_payload | input | DATA_W | Line contents |
| unb_valid | output | 1 | Unblock strobe |
| unb_line | output | LINE_W | Unblocked line |
| mru_valid | output | 1 | Recency update strobe |
| mru_line | output | LINE_W | Line to mark most recent |
| look_line | input | LINE_W | Lookup index |
| look_state | output | 3 | Stored state of looked-up line |
| look_dirty | output | 1 | Dirty bit of looked-up line |
| look_data | output | DATA_W | Data of looked-up line |
| look_busy | output | 1 | Writeback pending on looked-up line |

## Verification
On every cycle, the assertions check the handshake-to-strobe timing: an acknowledge follows each accepted victim, an unblock follows each completion and each accepted cancel, and an MRU strobe never appears without an unblock. They also check that a full table holds off new victims, and that a cancel and a completion never fire in the same cycle. Only the bench's scenarios can show the state resolution table, the dirty-bit merge, cancel restoring the prior state, and the refusal of foreign-requester cancels. These are shown by comparing the lookup port against a reference model over directed and random sequences.

// File: rtl/vwb_pkg.sv
package vwb_pkg;

  typedef enum logic [2:0] {
    LS_I = 3'd0,
    LS_S = 3'd1,
    LS_E = 3'd2,
    LS_O = 3'd3,
    LS_M = 3'd4
  } line_st_e;

  // Final stable state once writeback data arrives.
  function automatic line_st_e resolve_state(line_st_e prior, logic v_dirty,
                                             logic v_shared, logic d_shared);
    line_st_e r;
    case (prior)
      LS_I, LS_E: begin
        if (v_dirty) r = (v_shared || d_shared) ? LS_O : LS_M;
        else         r = (v_shared || d_shared) ? LS_S : LS_E;
      end
      LS_S:    r = v_dirty ? LS_O : LS_S;
      LS_O:    r = LS_O;
      default: r = d_shared ? LS_O : LS_M;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vwb_trk_table.sv
module vwb_trk_table
  import vwb_pkg::*;
#(
  parameter int TRK    = 4,
  parameter int LINE_W = 3,
  parameter int SRC_W  = 3,
  localparam int TRK_W = (TRK > 1) ? $clog2(TRK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic [SRC_W-1:0]  alloc_src,
  input  line_st_e          alloc_prior,
  input  logic              alloc_dirty,
  input  logic              alloc_shared,
  input  logic              free_en,
  input  logic [TRK_W-1:0]  free_idx,
  input  logic [LINE_W-1:0] qa_line,
  output logic              qa_hit,
  output logic [TRK_W-1:0]  qa_idx,
  output logic [SRC_W-1:0]  qa_src,
  input  logic [LINE_W-1:0] qb_line,
  output logic              qb_hit,
  output logic [TRK_W-1:0]  qb_idx,
  output line_st_e          qb_prior,
  output logic              qb_dirty,
  output logic              qb_shared,
  input  logic [LINE_W-1:0] qc_line,
  output logic              qc_hit,
  output logic              full
);

  logic              v_q    [TRK];
  logic [LINE_W-1:0] line_q [TRK];
  logic [SRC_W-1:0]  src_q  [TRK];
  line_st_e          pri_q  [TRK];
  logic              vd_q   [TRK];
  logic              vs_q   [TRK];

  logic              any_free;
  logic [TRK_W-1:0]  free_slot;

  always_comb begin
    any_free  = 1'b0;
    free_slot = '0;
    for (int i = 0; i < TRK; i++) begin
      if (!v_q[i] && !any_free) begin
        any_free  = 1'b1;
        free_slot = TRK_W'(i);
      end
    end
  end
  assign full = !any_free;

  always_comb begin
    qa_hit = 1'b0; qa_idx = '0;
    qb_hit = 1'b0; qb_idx = '0;
    qc_hit = 1'b0;
    for (int i = 0; i < TRK; i++) begin
      if (v_q[i] && line_q[i] == qa_line) begin qa_hit = 1'b1; qa_idx = TRK_W'(i); end
      if (v_q[i] && line_q[i] == qb_line) begin qb_hit = 1'b1; qb_idx = TRK_W'(i); end
      if (v_q[i] && line_q[i] == qc_line) qc_hit = 1'b1;
    end
  end

  assign qa_src    = src_q[qa_idx];
  assign qb_prior  = pri_q[qb_idx];
  assign qb_dirty  = vd_q[qb_idx];
  assign qb_shared = vs_q[qb_idx];

  for (genvar g = 0; g < TRK; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[g]    <= 1'b0;
        line_q[g] <= '0;
        src_q[g]  <= '0;
        pri_q[g]  <= LS_I;
        vd_q[g]   <= 1'b0;
        vs_q[g]   <= 1'b0;
      end else if (alloc_en && any_free && free_slot == TRK_W'(g)) begin
        v_q[g]    <= 1'b1;
        line_q[g] <= alloc_line;
        src_q[g]  <= alloc_src;
        pri_q[g]  <= alloc_prior;
        vd_q[g]   <= alloc_dirty;
        vs_q[g]   <= alloc_shared;
      end else if (free_en && free_idx == TRK_W'(g)) begin
        v_q[g]    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vwb_line_store.sv
module vwb_line_store
  import vwb_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DATA_W = 16,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  line_st_e          wr_state,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_set_dirty,
  input  logic [LINE_W-1:0] a_line,
  output line_st_e          a_state,
  input  logic [LINE_W-1:0] b_line,
  output line_st_e          b_state,
  output logic              b_dirty,
  output logic [DATA_W-1:0] b_data
);

  line_st_e          st_q    [LINES];
  logic              dirty_q [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]    <= LS_I;
        dirty_q[g] <= 1'b0;
        data_q[g]  <= '0;
      end else if (wr_en && wr_line == LINE_W'(g)) begin
        st_q[g]   <= wr_state;
        data_q[g] <= wr_data;
        if (wr_set_dirty) dirty_q[g] <= 1'b1;
      end
    end
  end

  assign a_state = st_q[a_line];
  assign b_state = st_q[b_line];
  assign b_dirty = dirty_q[b_line];
  assign b_data  = data_q[b_line];

endmodule

// File: rtl/vwb_accept_ctrl.sv
module vwb_accept_ctrl
  import vwb_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DATA_W = 16,
  parameter int SRC_W  = 3,
  parameter int TRK    = 4,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int TRK_W  = (TRK > 1) ? $clog2(TRK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_cancel,
  input  logic              req_dirty,
  input  logic              req_shared,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [LINE_W-1:0] req_line,
  output logic              ack_valid,
  output logic [SRC_W-1:0]  ack_src,
  output logic [LINE_W-1:0] ack_line,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [LINE_W-1:0] dat_line,
  input  logic              dat_shared,
  input  logic              dat_dirty,
  input  logic [DATA_W-1:0] dat_payload,
  output logic              unb_valid,
  output logic [LINE_W-1:0] unb_line,
  output logic              mru_valid,
  output logic [LINE_W-1:0] mru_line,
  input  logic [LINE_W-1:0] look_line,
  output logic [2:0]        look_state,
  output logic              look_dirty,
  output logic [DATA_W-1:0] look_data,
  output logic              look_busy
);

  logic             ra_hit, rb_hit, trk_full;
  logic [TRK_W-1:0] ra_idx, rb_idx;
  logic [SRC_W-1:0] ra_src;
  line_st_e         rb_prior, req_prior, look_st;
  logic             rb_vd, rb_vs;
  logic             dat_fire, vic_fire, cnl_fire, cnl_ok, vic_ok;

  assign dat_ready = rb_hit;
  assign dat_fire  = dat_valid && dat_ready;

  assign vic_ok   = !req_cancel && !ra_hit && !trk_full;
  assign cnl_ok   = req_cancel && ra_hit && (ra_src == req_src) && !dat_fire;
  assign req_ready = vic_ok || cnl_ok;
  assign vic_fire = req_valid && vic_ok;
  assign cnl_fire = req_valid && cnl_ok;

  vwb_trk_table #(.TRK(TRK), .LINE_W(LINE_W), .SRC_W(SRC_W)) trk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_en     (vic_fire),
    .alloc_line   (req_line),
    .alloc_src    (req_src),
    .alloc_prior  (req_prior),
    .alloc_dirty  (req_dirty),
    .alloc_shared (req_shared),
    .free_en      (dat_fire || cnl_fire),
    .free_idx     (dat_fire ? rb_idx : ra_idx),
    .qa_line      (req_line),
    .qa_hit       (ra_hit),
    .qa_idx       (ra_idx),
    .qa_src       (ra_src),
    .qb_line      (dat_line),
    .qb_hit       (rb_hit),
    .qb_idx       (rb_idx),
    .qb_prior     (rb_prior),
    .qb_dirty     (rb_vd),
    .qb_shared    (rb_vs),
    .qc_line      (look_line),
    .qc_hit       (look_busy),
    .full         (trk_full)
  );

  vwb_line_store #(.LINES(LINES), .DATA_W(DATA_W)) store_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (dat_fire),
    .wr_line      (dat_line),
    .wr_state     (resolve_state(rb_prior, rb_vd, rb_vs, dat_shared)),
    .wr_data      (dat_payload),
    .wr_set_dirty (dat_dirty),
    .a_line       (req_line),
    .a_state      (req_prior),
    .b_line       (look_line),
    .b_state      (look_st),
    .b_dirty      (look_dirty),
    .b_data       (look_data)
  );

  assign look_state = look_st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_src   <= '0;
      ack_line  <= '0;
      unb_valid <= 1'b0;
      unb_line  <= '0;
      mru_valid <= 1'b0;
      mru_line  <= '0;
    end else begin
      ack_valid <= vic_fire;
      if (vic_fire) begin
        ack_src  <= req_src;
        ack_line <= req_line;
      end
      unb_valid <= dat_fire || cnl_fire;
      if (dat_fire)      unb_line <= dat_line;
      else if (cnl_fire) unb_line <= req_line;
      mru_valid <= dat_fire && (rb_prior != LS_I);
      if (dat_fire) mru_line <= dat_line;
    end
  end

endmodule

// File: rtl/vwb_accept_chk.sv
module vwb_accept_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_cancel,
  input logic ack_valid,
  input logic dat_valid,
  input logic dat_ready,
  input logic unb_valid,
  input logic mru_valid,
  input logic trk_full
);

  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_cancel) |=> ack_valid);

  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_full && !req_cancel) |-> !req_ready);

  assert_mru_with_unb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mru_valid |-> unb_valid);

  assert_unb_after_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && dat_ready) |=> unb_valid);

  assert_unb_after_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_cancel) |=> unb_valid);

  assert_cancel_data_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_cancel && dat_valid && dat_ready));

endmodule

bind vwb_accept_ctrl vwb_accept_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_cancel (req_cancel),
  .ack_valid  (ack_valid),
  .dat_valid  (dat_valid),
  .dat_ready  (dat_ready),
  .unb_valid  (unb_valid),
  .mru_valid  (mru_valid),
  .trk_full   (trk_full)
);

// File: tb/vwb_accept_ctrl_tb_top.sv
`timescale 1ns/1ps
module vwb_accept_ctrl_tb_top;

  localparam int LINES = 8, DATA_W = 16, SRC_W = 3, TRK = 4, LINE_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid = 0, req_ready, req_cancel = 0, req_dirty = 0, req_shared = 0;
  logic [SRC_W-1:0]  req_src = 0;
  logic [LINE_W-1:0] req_line = 0;
  logic              ack_valid;
  logic [SRC_W-1:0]  ack_src;
  logic [LINE_W-1:0] ack_line;
  logic              dat_valid = 0, dat_ready, dat_shared = 0, dat_dirty = 0;
  logic [LINE_W-1:0] dat_line = 0;
  logic [DATA_W-1:0] dat_payload = 0;
  logic              unb_valid, mru_valid;
  logic [LINE_W-1:0] unb_line, mru_line, look_line = 0;
  logic [2:0]        look_state;
  logic              look_dirty, look_busy;
  logic [DATA_W-1:0] look_data;

  vwb_accept_ctrl #(.LINES(LINES), .DATA_W(DATA_W), .SRC_W(SRC_W), .TRK(TRK)) dut_i (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  int          m_st    [LINES];
  bit          m_dirty [LINES];
  int unsigned m_data  [LINES];
  bit          m_busy  [LINES];
  int          m_src   [LINES];
  int          m_pri   [LINES];
  bit          m_vd    [LINES];
  bit          m_vs    [LINES];
  int          m_cnt = 0;

  function automatic int exp_final(int p, bit vd, bit vs, bit ds);
    if (p == 0 || p == 2) begin
      if (vd) return (vs || ds) ? 3 : 4;
      return (vs || ds) ? 1 : 2;
    end
    if (p == 1) return vd ? 3 : 1;
    if (p == 3) return 3;
    return ds ? 3 : 4;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic look_chk(int ln, string tag);
    look_line = LINE_W'(ln);
    #1;
    chk(int'(look_state) == m_st[ln], {tag, " state"}, int'(look_state), m_st[ln]);
    chk(look_dirty == m_dirty[ln], {tag, " dirty"}, int'(look_dirty), int'(m_dirty[ln]));
    chk(int'(look_data) == int'(m_data[ln]), {tag, " data"}, int'(look_data), int'(m_data[ln]));
    chk(look_busy == m_busy[ln], {tag, " busy"}, int'(look_busy), int'(m_busy[ln]));
  endtask

  task automatic victim(int ln, bit d, bit s, int src);
    bit er;
    @(negedge clk);
    req_valid = 1; req_cancel = 0; req_dirty = d; req_shared = s;
    req_src = SRC_W'(src); req_line = LINE_W'(ln);
    #1;
    er = !m_busy[ln] && (m_cnt < TRK);
    chk(req_ready == er, "R3 victim ready", int'(req_ready), int'(er));
    @(posedge clk); #1;
    req_valid = 0;
    chk(ack_valid == er, "R2 ack", int'(ack_valid), int'(er));
    if (er) begin
      chk(int'(ack_src) == src && int'(ack_line) == ln, "R2 ack fields",
          int'(ack_src), src);
      m_busy[ln] = 1; m_src[ln] = src; m_pri[ln] = m_st[ln];
      m_vd[ln] = d; m_vs[ln] = s; m_cnt++;
    end
    look_chk(ln, "R2 after victim");
  endtask

  task automatic data(int ln, bit ds, bit dd, int unsigned pl);
    bit er;
    string t;
    @(negedge clk);
    dat_valid = 1; dat_line = LINE_W'(ln); dat_shared = ds; dat_dirty = dd;
    dat_payload = DATA_W'(pl);
    #1;
    er = m_busy[ln];
    chk(dat_ready == er, "R11 data ready", int'(dat_ready), int'(er));
    @(posedge clk); #1;
    dat_valid = 0;
    chk(unb_valid == er && (!er || int'(unb_line) == ln), "R8 unblock data",
        int'(unb_valid), int'(er));
    chk(mru_valid == (er && m_pri[ln] != 0) && (!mru_valid || int'(mru_line) == ln),
        "R7 mru", int'(mru_valid), int'(er && m_pri[ln] != 0));
    if (er) begin
      m_st[ln] = exp_final(m_pri[ln], m_vd[ln], m_vs[ln], ds);
      m_data[ln] = pl & 16'hFFFF;
      if (dd) m_dirty[ln] = 1;
      m_busy[ln] = 0; m_cnt--;
    end
    t = (m_pri[ln] == 0 || m_pri[ln] == 2) ? "R4 R6 completion" : "R5 R6 completion";
    look_chk(ln, t);
  endtask

  task automatic cancel(int ln, int src);
    bit er;
    @(negedge clk);
    req_valid = 1; req_cancel = 1; req_src = SRC_W'(src); req_line = LINE_W'(ln);
    #1;
    er = m_busy[ln] && m_src[ln] == src;
    chk(req_ready == er, "R9 cancel ready", int'(req_ready), int'(er));
    @(posedge clk); #1;
    req_valid = 0; req_cancel = 0;
    chk(unb_valid == er && (!er || int'(unb_line) == ln), "R8 unblock cancel",
        int'(unb_valid), int'(er));
    if (er) begin m_busy[ln] = 0; m_cnt--; end
    look_chk(ln, "R10 after cancel");
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_st[i] = 0; m_dirty[i] = 0; m_data[i] = 0; m_busy[i] = 0;
      m_src[i] = 0; m_pri[i] = 0; m_vd[i] = 0; m_vs[i] = 0;
    end
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!ack_valid && !unb_valid && !mru_valid, "R1 strobes idle",
        int'(ack_valid) + int'(unb_valid) + int'(mru_valid), 0);
    for (int i = 0; i < LINES; i++) look_chk(i, "R1 reset");

    // Directed: invalid-line mappings (R4).
    victim(0, 1, 0, 1); data(0, 0, 1, 16'h1111);   // M
    victim(1, 1, 0, 1); data(1, 1, 1, 16'h2222);   // O
    victim(2, 1, 1, 2); data(2, 0, 1, 16'h3333);   // O regardless
    victim(3, 0, 0, 2); data(3, 0, 0, 16'h4444);   // E
    victim(4, 0, 1, 3); data(4, 0, 0, 16'h5555);   // S
    // Directed: hits on valid lines (R5, R6, R7).
    victim(4, 1, 0, 3); data(4, 0, 0, 16'h6666);   // S -> O, dirty kept 0
    victim(0, 0, 0, 1); data(0, 1, 0, 16'h7777);   // M, shared data -> O, dirty kept 1
    victim(3, 1, 0, 2); data(3, 0, 1, 16'h8888);   // E -> M
    // Table full (R3), busy line (R3), stray data (R11).
    victim(5, 1, 0, 1); victim(6, 0, 0, 2); victim(7, 1, 1, 3); victim(1, 0, 0, 4);
    victim(2, 0, 0, 5);
    victim(5, 0, 0, 6);
    data(2, 0, 0, 16'h9999);
    // Wrong requester cancel (R9), good cancels (R10).
    cancel(5, 2);
    cancel(5, 1);
    cancel(1, 4);
    data(6, 1, 0, 16'hAAAA); data(7, 0, 1, 16'hBBBB);

    // Random mix.
    for (int n = 0; n < 600; n++) begin
      int op, ln, src;
      op = int'($urandom % 3); ln = int'($urandom % LINES); src = int'($urandom % 4);
      if (op == 0) victim(ln, 1'($urandom), 1'($urandom), src);
      else if (op == 1) data(ln, 1'($urandom), 1'($urandom), $urandom % 65536);
      else cancel(ln, ($urandom % 2 == 1) ? m_src[ln] : src);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule